// File: doc/BRIEF.md
# Vertical Beam Line Counter with Line-Match Interrupt

This block tracks the vertical beam position of a television-style video output. A free-running timebase strobe (`line_tick`) is divided down to one line advance every `TICKS_PER_LINE` strobes. On each line advance the line counter is incremented. The incremented value is compared with a programmable trigger line. Then the counter wraps back to line 1 once it reaches the number of lines in the current frame. That line count comes from a display-control word. The word picks a PAL-like or NTSC-like format group and selects interlaced or double-strike (non-interlaced) timing.

An interrupt-control word holds the trigger line, an enable bit and a sticky match flag. When the counter hits the trigger line, the flag is set. The interrupt request is raised only if the enable bit is also set. Software clears the request by writing the interrupt-control word with the flag bit clear. The current line is also presented inside a 32-bit position word. A one-cycle end-of-frame strobe marks every wrap.

The line sequencer is a three-state machine:
- `SEQ_IDLE`: line 0, the state after reset, before any line advance.
- `SEQ_RUN`: inside a frame.
- `SEQ_WRAP`: the single cycle after a wrap to line 1, while `frame_end` is high.

Its transitions are:
- `IDLE->RUN` and `WRAP->RUN`: a non-wrapping advance.
- `IDLE->WRAP`, `RUN->WRAP` and `WRAP->WRAP`: a wrapping advance.
- `WRAP->RUN`: a cycle with no advance.
- Any other cycle leaves the state unchanged.

Top module: `vbl_line_irq`

## Requirements
- R1: After reset, `line_now`, `pos_word` and `int_word` are all zero, and `irq` and `frame_end` are low.
- R2: The line counter advances by exactly one on every `TICKS_PER_LINE`-th sampled `line_tick`. The count starts after reset or after the last display-control write. Cycles without a tick leave the line unchanged.
- R3: Bit 2 of the display-control word selects the line count. When it is set, timing is double-strike; when it is clear, timing is interlaced. Format bits 9:8 equal to 1 select the PAL-like group, with 312 double-strike or 625 interlaced lines. Format codes 0, 2 and 3 select the NTSC-like group, with 262 double-strike or 525 interlaced lines, so code 2 behaves exactly like code 0.
- R4: When the incremented line is greater than or equal to the line count of the current mode, the counter reloads to 1. This also covers a mode change that leaves the counter above the new line count. `frame_end` is then high for exactly the one cycle after that advance.
- R5: The trigger line is bits 10:0 of the interrupt-control word. It is compared with the incremented line before any wrap. A trigger equal to the line count therefore matches on the wrapping advance. A trigger of 1 matches only on the first advance out of reset.
- R6: A match sets bit 31 (the flag) of the interrupt-control word. The flag stays set until a write to that word clears it. A match in the same cycle as a write sets bit 31 on top of the written value.
- R7: A match raises `irq` only when bit 28 (the enable) of the interrupt-control word is set after that cycle's write. With the enable clear, the flag is set and `irq` stays low.
- R8: Writing the interrupt-control word with bit 31 clear lowers `irq` unless a match happens in the same cycle. Writing it with bit 31 set leaves `irq` unchanged.
- R9: `pos_word` carries the current line in bits 26:16, and every other bit of it is zero.
- R10: A display-control write restarts the tick phase. A `line_tick` sampled in the same cycle as that write is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | Timebase strobe; `TICKS_PER_LINE` strobes make one line |
| dc_we | input | 1 | Display-control write strobe |
| dc_wdata | input | 16 | Display-control word (bit 2 double-strike, bits 9:8 format) |
| ic_we | input | 1 | Interrupt-control write strobe |
| ic_wdata | input | 32 | Interrupt-control word (bit 31 flag, bit 28 enable, bits 10:0 trigger) |
| pos_word | output | 32 | Position word with the current line in bits 26:16 |
| line_now | output | 11 | Current line number |
| int_word | output | 32 | Stored interrupt-control word including the flag |
| irq | output | 1 | Line-match interrupt request |
| frame_end | output | 1 | One-cycle pulse after each wrap to line 1 |

## Verification
The assertions assume that the interrupt-control word is not written while a strobe is sampled, whenever they reason about the request being cleared; the clear property is qualified on `line_tick` being low for exactly that reason. They also assume `TICKS_PER_LINE` is at least 2, so two wraps can never fall on adjacent cycles. The bench keeps within this by issuing every interrupt-control write as a cycle of its own without a tick. It then sweeps all eight format/interlace combinations through more than a full frame, with periodic tick gaps, against line counts computed from the mode bits.

// File: rtl/vbl_pkg.sv
package vbl_pkg;

    // Display-control field positions (decoded by the mode logic)
    localparam int DC_DBLSTRIKE_BIT = 2;
    localparam int DC_FMT_LO        = 8;
    localparam int DC_FMT_W         = 2;

    // Interrupt-control field positions
    localparam int IC_FLAG_BIT = 31;
    localparam int IC_EN_BIT   = 28;

    // Position word: line field start
    localparam int POS_SHIFT = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_WRAP = 2'd2
    } seq_state_t;

    typedef enum logic {
        GRP_NTSC_LIKE = 1'b0,
        GRP_PAL_LIKE  = 1'b1
    } fmt_group_t;

    // Format code 1 is the PAL-like group; every other code runs NTSC-like.
    function automatic fmt_group_t group_of(input logic [DC_FMT_W-1:0] code);
        return (code == 2'd1) ? GRP_PAL_LIKE : GRP_NTSC_LIKE;
    endfunction

endpackage

// File: rtl/vbl_mode_decode.sv
module vbl_mode_decode
    import vbl_pkg::*;
#(
    parameter int LINE_W        = 11,
    parameter int PAL_INTER     = 625,
    parameter int PAL_DBL       = 312,
    parameter int NTSC_INTER    = 525,
    parameter int NTSC_DBL      = 262
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dc_we,
    input  logic [15:0]       dc_wdata,
    output logic [LINE_W-1:0] modulus
);

    logic                dbl_q;
    logic [DC_FMT_W-1:0] fmt_q;
    fmt_group_t          grp;
    logic                dc_unused;

    assign dc_unused = ^{dc_wdata[15:DC_FMT_LO+DC_FMT_W],
                         dc_wdata[DC_FMT_LO-1:DC_DBLSTRIKE_BIT+1],
                         dc_wdata[DC_DBLSTRIKE_BIT-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbl_q <= 1'b0;
            fmt_q <= '0;
        end else if (dc_we) begin
            dbl_q <= dc_wdata[DC_DBLSTRIKE_BIT];
            fmt_q <= dc_wdata[DC_FMT_LO +: DC_FMT_W];
        end
    end

    assign grp = group_of(fmt_q);

    always_comb begin
        unique case (grp)
            GRP_PAL_LIKE:  modulus = dbl_q ? LINE_W'(PAL_DBL)  : LINE_W'(PAL_INTER);
            GRP_NTSC_LIKE: modulus = dbl_q ? LINE_W'(NTSC_DBL) : LINE_W'(NTSC_INTER);
            default:       modulus = LINE_W'(NTSC_INTER);
        endcase
    end

endmodule

// File: rtl/vbl_tick_phase.sv
module vbl_tick_phase #(
    parameter int TICKS_PER_LINE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic restart,
    output logic adv
);

    generate
        if (TICKS_PER_LINE <= 1) begin : g_direct
            logic clk_unused;
            assign clk_unused = clk ^ rst_n;
            assign adv = line_tick && !restart;
        end else begin : g_divide
            localparam int PW = $clog2(TICKS_PER_LINE);
            localparam logic [PW-1:0] LAST = PW'(TICKS_PER_LINE - 1);
            logic [PW-1:0] phase_q;

            assign adv = line_tick && !restart && (phase_q == LAST);

            always_ff @(posedge clk) begin
                if (!rst_n || restart) begin
                    phase_q <= '0;
                end else if (line_tick) begin
                    phase_q <= (phase_q == LAST) ? '0 : phase_q + PW'(1);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/vbl_line_seq.sv
module vbl_line_seq
    import vbl_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [LINE_W-1:0] modulus,
    input  logic [LINE_W-1:0] trigger,
    output logic [LINE_W-1:0] line_q,
    output logic              match,
    output logic              frame_end
);

    seq_state_t        state_q, state_d;
    logic [LINE_W:0]   inc;
    logic              wrap;

    assign inc   = {1'b0, line_q} + (LINE_W+1)'(1);
    assign wrap  = inc >= {1'b0, modulus};
    assign match = adv && (inc == {1'b0, trigger});

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (adv) state_d = wrap ? SEQ_WRAP : SEQ_RUN;
            SEQ_RUN:  if (adv && wrap) state_d = SEQ_WRAP;
            SEQ_WRAP: state_d = (adv && wrap) ? SEQ_WRAP : SEQ_RUN;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    // Outputs: line register and wrap strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (adv) begin
            line_q <= wrap ? LINE_W'(1) : inc[LINE_W-1:0];
        end
    end

    assign frame_end = (state_q == SEQ_WRAP);

endmodule

// File: rtl/vbl_irq_ctl.sv
module vbl_irq_ctl
    import vbl_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ic_we,
    input  logic [31:0]       ic_wdata,
    input  logic              match,
    output logic [31:0]       int_word,
    output logic [LINE_W-1:0] trigger,
    output logic              irq
);

    logic [31:0] word_d;
    logic        irq_d;

    assign trigger = int_word[LINE_W-1:0];

    always_comb begin
        word_d = ic_we ? ic_wdata : int_word;
        if (match) word_d[IC_FLAG_BIT] = 1'b1;

        irq_d = irq;
        if (match && word_d[IC_EN_BIT])            irq_d = 1'b1;
        else if (ic_we && !ic_wdata[IC_FLAG_BIT])  irq_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_word <= '0;
            irq      <= 1'b0;
        end else begin
            int_word <= word_d;
            irq      <= irq_d;
        end
    end

endmodule

// File: rtl/vbl_line_irq.sv
module vbl_line_irq
    import vbl_pkg::*;
#(
    parameter int LINE_W         = 11,
    parameter int TICKS_PER_LINE = 2,
    parameter int PAL_INTER      = 625,
    parameter int PAL_DBL        = 312,
    parameter int NTSC_INTER     = 525,
    parameter int NTSC_DBL       = 262
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              dc_we,
    input  logic [15:0]       dc_wdata,
    input  logic              ic_we,
    input  logic [31:0]       ic_wdata,
    output logic [31:0]       pos_word,
    output logic [LINE_W-1:0] line_now,
    output logic [31:0]       int_word,
    output logic              irq,
    output logic              frame_end
);

    localparam int POS_HI_PAD = 32 - POS_SHIFT - LINE_W;

    logic [LINE_W-1:0] modulus;
    logic [LINE_W-1:0] trigger;
    logic              adv;
    logic              match;

    vbl_mode_decode #(
        .LINE_W     (LINE_W),
        .PAL_INTER  (PAL_INTER),
        .PAL_DBL    (PAL_DBL),
        .NTSC_INTER (NTSC_INTER),
        .NTSC_DBL   (NTSC_DBL)
    ) i_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .dc_we    (dc_we),
        .dc_wdata (dc_wdata),
        .modulus  (modulus)
    );

    vbl_tick_phase #(
        .TICKS_PER_LINE (TICKS_PER_LINE)
    ) i_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_tick (line_tick),
        .restart   (dc_we),
        .adv       (adv)
    );

    vbl_line_seq #(
        .LINE_W (LINE_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .modulus   (modulus),
        .trigger   (trigger),
        .line_q    (line_now),
        .match     (match),
        .frame_end (frame_end)
    );

    vbl_irq_ctl #(
        .LINE_W (LINE_W)
    ) i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ic_we    (ic_we),
        .ic_wdata (ic_wdata),
        .match    (match),
        .int_word (int_word),
        .trigger  (trigger),
        .irq      (irq)
    );

    assign pos_word = {{POS_HI_PAD{1'b0}}, line_now, {POS_SHIFT{1'b0}}};

endmodule

// File: rtl/vbl_line_irq_chk.sv
module vbl_line_irq_chk #(
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_tick,
    input logic              ic_we,
    input logic              ic_flag_wr,
    input logic [LINE_W-1:0] line_now,
    input logic              flag,
    input logic              enable,
    input logic              irq,
    input logic              frame_end
);

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(line_now));

    // R4
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_now != $past(line_now)) |->
            (line_now == $past(line_now) + LINE_W'(1) || line_now == LINE_W'(1)));

    // R4
    wrap_line_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> line_now == LINE_W'(1));

    // R4
    wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ic_we) |=> flag);

    // R7
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (enable && flag));

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_we && !ic_flag_wr && !line_tick) |=> !irq);

endmodule

bind vbl_line_irq vbl_line_irq_chk #(.LINE_W(LINE_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_tick  (line_tick),
    .ic_we      (ic_we),
    .ic_flag_wr (ic_wdata[31]),
    .line_now   (line_now),
    .flag       (int_word[31]),
    .enable     (int_word[28]),
    .irq        (irq),
    .frame_end  (frame_end)
);

// File: tb/test_vbl_line_irq.sv
module test_vbl_line_irq;

    localparam int CLK_PERIOD = 10;
    localparam int TPL        = 2;
    localparam int LW         = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_tick = 1'b0;
    logic          dc_we = 1'b0;
    logic [15:0]   dc_wdata = '0;
    logic          ic_we = 1'b0;
    logic [31:0]   ic_wdata = '0;
    logic [31:0]   pos_word;
    logic [LW-1:0] line_now;
    logic [31:0]   int_word;
    logic          irq;
    logic          frame_end;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench-side expectation
    int          e_line;
    int          e_phase;
    logic [15:0] e_dc;
    logic [31:0] e_iw;
    logic        e_irq;
    logic        e_fe;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbl_line_irq #(.LINE_W(LW), .TICKS_PER_LINE(TPL)) i_vbl_line_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_tick (line_tick),
        .dc_we     (dc_we),
        .dc_wdata  (dc_wdata),
        .ic_we     (ic_we),
        .ic_wdata  (ic_wdata),
        .pos_word  (pos_word),
        .line_now  (line_now),
        .int_word  (int_word),
        .irq       (irq),
        .frame_end (frame_end)
    );

    // R3: line count from mode bits
    function automatic int lines_for(input logic [15:0] dc);
        if (dc[9:8] == 2'd1) return dc[2] ? 312 : 625;
        return dc[2] ? 262 : 525;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [31:0] e_pos;
        e_pos = 32'(e_line) << 16;
        chk({tag, " R2 line"}, line_now, e_line);
        chk({tag, " R9 pos_word"}, pos_word, e_pos);
        chk({tag, " R4 frame_end"}, frame_end, e_fe);
        chk({tag, " R6 int_word"}, int_word, e_iw);
        chk({tag, " R7 irq"}, irq, e_irq);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e_line = 0; e_phase = 0; e_dc = '0; e_iw = '0; e_irq = 1'b0; e_fe = 1'b0;
    endtask

    // One cycle of stimulus; called at a negedge, returns at the next negedge.
    task automatic cyc(input logic t, input logic dw, input logic [15:0] dv,
                       input logic iw, input logic [31:0] iv, input string tag);
        logic adv, match, wrap;
        int   inc;
        line_tick = t; dc_we = dw; dc_wdata = dv; ic_we = iw; ic_wdata = iv;
        @(posedge clk);
        adv = 1'b0; match = 1'b0; wrap = 1'b0;
        if (dw) begin
            e_phase = 0;
            e_dc = dv;
        end else if (t) begin
            if (e_phase == TPL - 1) begin
                adv = 1'b1;
                e_phase = 0;
            end else begin
                e_phase++;
            end
        end
        if (adv) begin
            inc   = e_line + 1;
            match = (inc == int'(e_iw[10:0]));
            wrap  = (inc >= lines_for(e_dc));
            e_line = wrap ? 1 : inc;
        end
        e_fe = wrap;
        if (iw) e_iw = iv;
        if (match) e_iw[31] = 1'b1;
        if (match && e_iw[28]) e_irq = 1'b1;
        else if (iw && !iv[31]) e_irq = 1'b0;
        @(negedge clk);
        line_tick = 1'b0; dc_we = 1'b0; ic_we = 1'b0;
        compare(tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, '0, 1'b0, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        compare("R1 reset");

        // R2 / R10: phase counting and restart
        cyc(1'b1, 1'b0, '0, 1'b0, '0, "R2 half line");
        cyc(1'b1, 1'b1, 16'h0000, 1'b0, '0, "R10 tick with dc write");
        cyc(1'b1, 1'b0, '0, 1'b0, '0, "R10 phase restarted");
        cyc(1'b1, 1'b0, '0, 1'b0, '0, "R2 first line");
        chk("R2 line after restart", line_now, 1);
        for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, '0, 1'b0, '0, "R2 idle gap");

        // R5: trigger 1 only on the first advance out of reset
        do_reset();
        cyc(1'b0, 1'b0, '0, 1'b1, 32'h1000_0001, "R5 arm trigger 1");
        ticks(2, "R5 trigger 1");
        chk("R5 flag on first advance", int_word[31], 1);
        chk("R7 irq on first advance", irq, 1);

        // R8: acknowledge with flag set keeps irq; with flag clear drops it
        cyc(1'b0, 1'b0, '0, 1'b1, 32'h9000_0001, "R8 write flag set");
        chk("R8 irq held", irq, 1);
        cyc(1'b0, 1'b0, '0, 1'b1, 32'h1000_0001, "R8 write flag clear");
        chk("R8 irq cleared", irq, 0);

        // R7: match without enable
        cyc(1'b0, 1'b0, '0, 1'b1, 32'h0000_0004, "R7 arm no enable");
        ticks(6, "R7 disabled match");
        chk("R7 flag set no enable", int_word[31], 1);
        chk("R7 irq stays low", irq, 0);
        cyc(1'b0, 1'b0, '0, 1'b1, 32'h0000_0000, "R6 clear flag");
        chk("R6 flag cleared by write", int_word[31], 0);

        // R3 / R4 / R5: sweep every format and interlace combination
        for (int f = 0; f < 4; f++) begin
            for (int d = 0; d < 2; d++) begin
                logic [15:0] dcv;
                int          lc, fe_seen, last_before;
                dcv = 16'((f << 8) | (d << 2));
                lc  = lines_for(dcv);
                cyc(1'b0, 1'b1, dcv, 1'b0, '0, "R3 mode write");
                cyc(1'b0, 1'b0, '0, 1'b1, 32'h1000_0000 | 32'(lc), "R5 trigger at count");
                fe_seen = 0;
                last_before = -1;
                for (int k = 0; k < (lc + 4) * TPL + (lc + 4) * TPL / 4; k++) begin
                    int prev;
                    prev = int'(line_now);
                    cyc((k % 5) != 4, 1'b0, '0, 1'b0, '0, "R3 sweep");
                    if (frame_end) begin
                        fe_seen++;
                        last_before = prev;
                    end
                end
                chk("R4 wrap seen", fe_seen >= 1, 1);
                if (fe_seen > 1 || f > 0 || d > 0)
                    chk("R3 last line before wrap", last_before, lc - 1);
                chk("R5 flag at wrap trigger", int_word[31], 1);
                cyc(1'b0, 1'b0, '0, 1'b1, '0, "R8 clear after sweep");
                chk("R8 irq low after clear", irq, 0);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule